// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter made of identical 4-bit stages. Every state bit is a flop on the rising edge of one clock, so all output bits change in the same cycle and never ripple. Each stage takes an active-low preset (`load_n`), an active-low clear (`clr_n`) and two count enables. `enp` goes to every stage. `ent` gates both counting and the stage's carry output. The carry output of each stage drives the `ent` input of the next stage, so the chain behaves as one wide binary counter and needs no extra gating.

The top module chains `STAGES` stages of `SW` bits. The parameter `ASYNC_CLR` chooses between two clear modes. In one mode the clear acts at once, without waiting for a clock. In the other mode the clear is sampled at the next rising edge. The synchronous mode lets a combinational decode of a chosen count drive `clr_n`, which gives a modulus-N counter. The inputs are plain control pins. There is no data stream and no handshake, so nothing is ever back-pressured.

Top module: `casc_counter`

## Requirements
- R1: All bits of `q` are flops on the rising edge of `clk`. Apart from an asynchronous clear, `q` changes only at that edge.
- R2: When `load_n` is low at a rising edge and clear is inactive, `q` takes `d` at that edge, whatever the levels of `enp` and `ent`.
- R3: With `ASYNC_CLR`=1, a low `clr_n` forces `q` to all zeros at once, without a clock edge. `q` stays zero while `clr_n` is low, even with `load_n` low across an edge.
- R4: With `ASYNC_CLR`=0, a low `clr_n` at a rising edge sets `q` to zero at that edge, overriding load and both enables. Decoding count N-1 into `clr_n` gives the sequence 0..N-1 repeating.
- R5: When `enp` and `ent` are both high and load and clear are inactive, `q` increments by one at the edge. All ones wraps to all zeros.
- R6: `rco` is high exactly when `ent` is high and every bit of `q` is 1. It is combinational, so it falls in the same cycle that `ent` falls, with no clock edge needed.
- R7: With load and clear inactive, if `enp` or `ent` is low at an edge, `q` holds its value.
- R8: Stage k>0 takes the carry of stage k-1 as its T enable. The chained counter counts as one `STAGES*SW`-bit binary number (0x0F increments to 0x10), and `rco` is the carry of the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all stages |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous depending on `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous parallel preset |
| enp | input | 1 | Count enable shared by every stage |
| ent | input | 1 | Count enable for the first stage; also gates `rco` |
| d | input | STAGES*SW | Preset value |
| q | output | STAGES*SW | Count value |
| rco | output | 1 | Terminal-count carry of the whole chain |

## Verification
The bench builds two instances.

The first has two 4-bit stages with synchronous clear. This makes the carry between stages visible, including the step from 0x0F to 0x10 and the wrap at 0xFF. It also allows a modulus-10 sequence driven by decoding count 9 into the clear.

The second is a single stage with asynchronous clear. The bench pulls its clear low between clock edges and checks that the output reaches zero before any edge arrives.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int STAGE_BITS = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic clr_n,
  input  logic load_n,
  input  logic enp,
  input  logic ent,
  output op_e  op
);
  // Priority at the edge: clear, preset, count, hold.
  always_comb begin
    if (!clr_n)            op = OP_CLEAR;
    else if (!load_n)      op = OP_LOAD;
    else if (enp && ent)   op = OP_COUNT;
    else                   op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int W = STAGE_BITS
) (
  input  op_e          op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] d,
  output logic [W-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = d;
      OP_COUNT: nxt = cur + W'(1);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W         = STAGE_BITS,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         enp,
  input  logic         ent,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  op_e          op;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  cnt_mode_dec dec_i (
    .clr_n  (clr_n),
    .load_n (load_n),
    .enp    (enp),
    .ent    (ent),
    .op     (op)
  );

  cnt_next #(.W(W)) nxt_i (
    .op  (op),
    .cur (q_r),
    .d   (d),
    .nxt (q_nxt)
  );

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        q_r <= q_nxt;
      end
    end
  endgenerate

  assign q   = q_r;
  // Terminal-count carry, combinational so it follows ent without a clock.
  assign rco = ent & (&q_r);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int STAGES    = 2,
  parameter int SW        = STAGE_BITS,
  parameter bit ASYNC_CLR = 1'b0,
  localparam int TW       = STAGES * SW
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          enp,
  input  logic          ent,
  input  logic [TW-1:0] d,
  output logic [TW-1:0] q,
  output logic          rco
);
  logic [STAGES:0] carry;

  assign carry[0] = ent;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      cnt_stage #(.W(SW), .ASYNC_CLR(ASYNC_CLR)) stage_i (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .enp    (enp),
        .ent    (carry[g]),
        .d      (d[g*SW +: SW]),
        .q      (q[g*SW +: SW]),
        .rco    (carry[g+1])
      );
    end
  endgenerate

  assign rco = carry[STAGES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int TW        = 8,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic          clk,
  input logic          clr_n,
  input logic          load_n,
  input logic          enp,
  input logic          ent,
  input logic [TW-1:0] d,
  input logic [TW-1:0] q,
  input logic          rco
);
  AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(d)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && enp && ent) |=> q == $past(q) + TW'(1)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(enp && ent)) |=> $stable(q)); // R7

  AST_CARRY_TERMINAL: assert property (@(posedge clk) disable iff (!clr_n)
    rco == (ent && (q == {TW{1'b1}}))); // R6

  generate
    if (ASYNC_CLR) begin : g_async
      AST_CLEAR_NOW: assert property (@(posedge clk)
        !clr_n |-> q == '0); // R3
    end else begin : g_sync
      AST_CLEAR_NEXT: assert property (@(posedge clk)
        !clr_n |=> q == '0); // R4
    end
  endgenerate
endmodule

bind casc_counter casc_counter_chk #(.TW(TW), .ASYNC_CLR(ASYNC_CLR)) chk_i (.*);

// File: tb/casc_counter_tb_top.sv
`timescale 1ns/1ps
module casc_counter_tb_top;
  localparam int TW = 8;

  typedef struct {
    logic [TW-1:0] q;
    logic          rco;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          clr_n = 1'b0, load_n = 1'b1, enp = 1'b0, ent = 1'b0;
  logic [TW-1:0] d = '0;
  logic [TW-1:0] q;
  logic          rco;

  logic       a_clr_n = 1'b0, a_load_n = 1'b1;
  logic [3:0] a_d = '0;
  logic [3:0] a_q;
  logic       a_rco;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  exp_t sbq[$];
  logic [TW-1:0] mq = '0;

  casc_counter #(.STAGES(2), .SW(4), .ASYNC_CLR(1'b0)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .enp(enp), .ent(ent),
    .d(d), .q(q), .rco(rco));

  casc_counter #(.STAGES(1), .SW(4), .ASYNC_CLR(1'b1)) dut_a (
    .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .enp(enp), .ent(ent),
    .d(a_d), .q(a_q), .rco(a_rco));

  task automatic check(input bit ok, input string tag, input logic [TW-1:0] act,
                       input logic [TW-1:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus at the falling edge and queues the result.
  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [TW-1:0] dv, input string tag);
    exp_t e;
    clr_n = c; load_n = l; enp = p; ent = t; d = dv;
    if (!c)             mq = '0;
    else if (!l)        mq = dv;
    else if (p && t)    mq = mq + TW'(1);
    e.q = mq;
    e.rco = t && (mq == {TW{1'b1}});
    e.tag = tag;
    sbq.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares after each rising edge, away from it.
  always @(posedge clk) begin
    #3;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(q == e.q, e.tag, q, e.q);
      check(rco == e.rco, {e.tag, " rco"}, TW'(rco), TW'(e.rco));
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(q == '0, "R4 reset", q, '0);
    check(a_q == '0, "R3 reset", TW'(a_q), '0);
    a_clr_n = 1'b1;

    // Asynchronous stage: preset, then clear between edges.
    a_load_n = 1'b0; a_d = 4'hA;
    @(posedge clk); @(negedge clk);
    check(a_q == 4'hA, "R2 async preset", TW'(a_q), 8'h0A);
    #1 a_clr_n = 1'b0;
    #1 check(a_q == 4'h0, "R3 clear without edge", TW'(a_q), 8'h00);
    a_d = 4'h7;
    @(posedge clk); @(negedge clk);
    check(a_q == 4'h0, "R3 clear holds over preset", TW'(a_q), 8'h00);
    a_clr_n = 1'b1; a_load_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(a_q == 4'h0, "R1 stays put after release", TW'(a_q), 8'h00);

    clr_n = 1'b1;
    mq = '0;
    for (int i = 0; i < 20; i++) step(1, 1, 1, 1, '0, "R5 count");
    step(1, 0, 0, 0, 8'hF3, "R2 preset enables low");
    step(1, 0, 1, 1, 8'h0E, "R2 preset enables high");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, '0, "R7 hold enp low");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, '0, "R7 hold ent low");
    step(1, 0, 0, 0, 8'h0D, "R2 preset");
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, '0, "R8 stage carry");
    step(1, 0, 0, 0, 8'hFD, "R2 preset");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, '0, "R5 wrap R6 carry");
    step(0, 0, 1, 1, 8'h55, "R4 sync clear beats preset");
    for (int i = 0; i < 25; i++)
      step((mq == 8'd9) ? 1'b0 : 1'b1, 1, 1, 1, '0, "R4 modulus ten");
    step(1, 0, 0, 0, 8'hFF, "R2 preset all ones");
    step(1, 1, 1, 0, '0, "R6 carry gated by ent");
    step(1, 1, 0, 1, '0, "R6 carry at terminal");

    // Carry must follow ent with no clock edge.
    check(rco == 1'b1, "R6 carry high", TW'(rco), 8'h01);
    #1 ent = 1'b0;
    #1 check(rco == 1'b0, "R6 carry falls with ent", TW'(rco), 8'h00);
    #1 ent = 1'b1;
    #1 check(rco == 1'b1, "R6 carry rises with ent", TW'(rco), 8'h01);

    step(1, 1, 1, 1, '0, "R5 R8 full wrap");
    @(posedge clk); #5;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule